// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a boundary-scan test access port for a programmable logic device. It follows the standard sixteen-state controller, clocked on the rising edge of the test clock, and steered by the mode-select input. A ten-bit instruction register chooses which data register sits between the serial input and the serial output. The data registers are a one-bit bypass stage, a 32-bit identification word, a 32-bit user word and a boundary register with two cells per user pin.

The boundary register supports two uses. It can take a snapshot of the pins while the core keeps running, and it can preload a pattern that a later external-test instruction drives onto the outputs. A float instruction turns off every user output enable and routes the bypass stage.

Test access is held off until a readiness input, meaning power good and configuration done, is high. Until then the controller is kept in its reset state.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: An active-low asynchronous `trst_n`, or five rising `tck` edges in a row with `tms` high from any state, puts the controller in Test-Logic-Reset.
- R2: While in Test-Logic-Reset the instruction register is loaded with the identification opcode 10'h006, so a data scan right after reset returns `ID_VALUE`, least significant bit first.
- R3: Capture-IR loads 10'b00_0000_0001 into the instruction shift stage, and Shift-IR moves it out least significant bit first.
- R4: The opcodes are 10'h006 (identification), 10'h007 (user word), 10'h3FF (bypass), 10'h005 (sample/preload), 10'h00F (external test) and 10'h00B (float). A newly shifted opcode takes effect only on the `tck` edge in Update-IR.
- R5: Bypass, float and every opcode not listed in R4 select the one-bit bypass stage. It captures 0 in Capture-DR and delays `tdi` by one shift.
- R6: The user word captures `USER_VALUE`, which defaults to 32'hFFFF_FFFF.
- R7: The boundary register is `2*NPINS` bits long. Bits [NPINS-1:0] are output cells and capture `core_out`. Bits [2*NPINS-1:NPINS] are input cells and capture `pin_in`. Under sample/preload, Update-DR copies the output cells into the pin latch while the pins keep following the core.
- R8: Under external test, `pin_out` equals the pin latch and every bit of `pin_oe` is 1.
- R9: Under the float instruction, every bit of `pin_oe` is 0.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only for the half-cycle that follows a rising edge in Shift-IR or Shift-DR.
- R11: While `ready` is low, every rising `tck` edge leaves the controller in Test-Logic-Reset, so no scan can start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (used when `HAS_TRST` is 1) |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| ready | input | 1 | Power good and configuration done |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| core_out | input | NPINS | Values the core logic wants on the pins |
| core_oe | input | NPINS | Output enables from the core logic |
| pin_in | input | NPINS | Values seen at the pins |
| pin_out | output | NPINS | Values driven to the pin buffers |
| pin_oe | output | NPINS | Output enables for the pin buffers |

## Verification
The properties assume that `tms` and `tdi` change only while `tck` is low, so each rising edge sees settled inputs. They also assume that `ready` moves only between edges and that `trst_n` is held low from time zero until the stimulus begins. The bench drives every input just after a falling edge and releases reset at the same point, which keeps to these limits. It samples `tdo` a half-cycle after each falling edge. A five-edge `tms` count kept in the checker, rather than a deep `$past`, checks the forced reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 10;
   typedef logic [IR_W-1:0] instr_t;

   localparam instr_t OP_SAMPLE  = 10'h005;
   localparam instr_t OP_IDCODE  = 10'h006;
   localparam instr_t OP_USER    = 10'h007;
   localparam instr_t OP_HIGHZ   = 10'h00B;
   localparam instr_t OP_EXTEST  = 10'h00F;
   localparam instr_t OP_BYPASS  = 10'h3FF;
   localparam instr_t IR_CAPTURE = 10'h001;

   typedef enum logic [3:0] {
      ST_RESET   = 4'h0,
      ST_IDLE    = 4'h1,
      ST_SEL_DR  = 4'h2,
      ST_CAP_DR  = 4'h3,
      ST_SHF_DR  = 4'h4,
      ST_EX1_DR  = 4'h5,
      ST_PAU_DR  = 4'h6,
      ST_EX2_DR  = 4'h7,
      ST_UPD_DR  = 4'h8,
      ST_SEL_IR  = 4'h9,
      ST_CAP_IR  = 4'hA,
      ST_SHF_IR  = 4'hB,
      ST_EX1_IR  = 4'hC,
      ST_PAU_IR  = 4'hD,
      ST_EX2_IR  = 4'hE,
      ST_UPD_IR  = 4'hF
   } tap_state_t;

   typedef enum logic [1:0] {
      DR_BYPASS   = 2'd0,
      DR_IDENT    = 2'd1,
      DR_USER     = 2'd2,
      DR_BOUNDARY = 2'd3
   } dr_sel_t;

   function automatic dr_sel_t decode_dr(input instr_t op);
      dr_sel_t s;
      case (op)
         OP_IDCODE:            s = DR_IDENT;
         OP_USER:              s = DR_USER;
         OP_SAMPLE, OP_EXTEST: s = DR_BOUNDARY;
         default:              s = DR_BYPASS;
      endcase
      return s;
   endfunction

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      tap_state_t n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       ready,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         state <= ST_RESET;
      else if (!ready)
         state <= ST_RESET;
      else
         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  tap_state_t state,
   input  logic       tdi,
   output instr_t     instr,
   output logic       ir_so
);

   instr_t shf_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         shf_q <= '0;
      end else begin
         case (state)
            ST_CAP_IR: shf_q <= IR_CAPTURE;
            ST_SHF_IR: shf_q <= {tdi, shf_q[IR_W-1:1]};
            default:   shf_q <= shf_q;
         endcase
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         instr <= OP_IDCODE;
      else if (state == ST_RESET)
         instr <= OP_IDCODE;
      else if (state == ST_UPD_IR)
         instr <= shf_q;
   end

   assign ir_so = shf_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int          NPINS      = 8,
   parameter logic [31:0] ID_VALUE   = 32'h1234_50DD,
   parameter logic [31:0] USER_VALUE = 32'hFFFF_FFFF
) (
   input  logic             tck,
   input  logic             rst_n,
   input  tap_state_t       state,
   input  dr_sel_t          sel,
   input  logic             tdi,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] core_out,
   output logic             dr_so,
   output logic [NPINS-1:0] bsr_latch
);

   localparam int BSR_W  = 2 * NPINS;
   localparam int WORD_W = 32;

   logic              byp_q;
   logic [WORD_W-1:0] id_q;
   logic [WORD_W-1:0] usr_q;
   logic [BSR_W-1:0]  bsr_q;

   wire cap = (state == ST_CAP_DR);
   wire shf = (state == ST_SHF_DR);
   wire upd = (state == ST_UPD_DR);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         byp_q <= 1'b0;
      else if (sel == DR_BYPASS && cap)
         byp_q <= 1'b0;
      else if (sel == DR_BYPASS && shf)
         byp_q <= tdi;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         id_q <= '0;
      else if (sel == DR_IDENT && cap)
         id_q <= ID_VALUE;
      else if (sel == DR_IDENT && shf)
         id_q <= {tdi, id_q[WORD_W-1:1]};
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         usr_q <= '0;
      else if (sel == DR_USER && cap)
         usr_q <= USER_VALUE;
      else if (sel == DR_USER && shf)
         usr_q <= {tdi, usr_q[WORD_W-1:1]};
   end

   // Boundary chain: one output cell and one input cell per pin.
   for (genvar g = 0; g < NPINS; g++) begin : g_cell
      wire out_next = (g == NPINS - 1) ? bsr_q[NPINS] : bsr_q[g+1];
      wire in_next  = (g == NPINS - 1) ? tdi          : bsr_q[NPINS+g+1];

      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n) begin
            bsr_q[g]       <= 1'b0;
            bsr_q[NPINS+g] <= 1'b0;
         end else if (sel == DR_BOUNDARY && cap) begin
            bsr_q[g]       <= core_out[g];
            bsr_q[NPINS+g] <= pin_in[g];
         end else if (sel == DR_BOUNDARY && shf) begin
            bsr_q[g]       <= out_next;
            bsr_q[NPINS+g] <= in_next;
         end
      end

      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n)
            bsr_latch[g] <= 1'b0;
         else if (sel == DR_BOUNDARY && upd)
            bsr_latch[g] <= bsr_q[g];
      end
   end

   always_comb begin
      case (sel)
         DR_IDENT:    dr_so = id_q[0];
         DR_USER:     dr_so = usr_q[0];
         DR_BOUNDARY: dr_so = bsr_q[0];
         default:     dr_so = byp_q;
      endcase
   end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
   import tap_pkg::*;
#(
   parameter int          NPINS      = 8,
   parameter logic [31:0] ID_VALUE   = 32'h1234_50DD,
   parameter logic [31:0] USER_VALUE = 32'hFFFF_FFFF,
   parameter bit          HAS_TRST   = 1'b1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   input  logic             ready,
   output logic             tdo,
   output logic             tdo_oe,
   input  logic [NPINS-1:0] core_out,
   input  logic [NPINS-1:0] core_oe,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe
);

   if (NPINS < 1) begin : g_bad_npins
      $error("NPINS must be at least 1");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("ID_VALUE bit 0 must be 1");
   end

   logic rst_n;
   if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_t       state;
   instr_t           ir_q;
   logic             ir_so;
   logic             dr_so;
   dr_sel_t          dr_sel;
   logic [NPINS-1:0] bsr_latch;

   tap_fsm u_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .ready (ready),
      .tms   (tms),
      .state (state)
   );

   tap_ir u_ir (
      .tck   (tck),
      .rst_n (rst_n),
      .state (state),
      .tdi   (tdi),
      .instr (ir_q),
      .ir_so (ir_so)
   );

   assign dr_sel = decode_dr(ir_q);

   tap_dr #(
      .NPINS      (NPINS),
      .ID_VALUE   (ID_VALUE),
      .USER_VALUE (USER_VALUE)
   ) u_dr (
      .tck       (tck),
      .rst_n     (rst_n),
      .state     (state),
      .sel       (dr_sel),
      .tdi       (tdi),
      .pin_in    (pin_in),
      .core_out  (core_out),
      .dr_so     (dr_so),
      .bsr_latch (bsr_latch)
   );

   // Serial output stage on the falling edge.
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (state == ST_SHF_IR) ? ir_so :
                   (state == ST_SHF_DR) ? dr_so : 1'b0;
         tdo_oe <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      end
   end

   wire ext_mode  = (ir_q == OP_EXTEST);
   wire hiz_mode  = (ir_q == OP_HIGHZ);

   assign pin_out = ext_mode ? bsr_latch : core_out;
   assign pin_oe  = hiz_mode ? '0 : (ext_mode ? '1 : core_oe);

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
   import tap_pkg::*;
#(
   parameter int NPINS = 8
) (
   input logic             tck,
   input logic             trst_n,
   input logic             ready,
   input logic             tms,
   input tap_state_t       state,
   input instr_t           ir_q,
   input logic             tdo_oe,
   input logic [NPINS-1:0] pin_oe
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         ones_cnt <= '0;
      else if (!tms)
         ones_cnt <= '0;
      else if (ones_cnt != 3'd5)
         ones_cnt <= ones_cnt + 3'd1;
   end

   assert_five_ones_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_cnt == 3'd5) |-> (state == ST_RESET));

   assert_reset_loads_id_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir_q == OP_IDCODE));

   assert_ir_holds_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_RESET && state != ST_UPD_IR) |=> $stable(ir_q));

   assert_extest_drive_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_q == OP_EXTEST) |-> (pin_oe == {NPINS{1'b1}}));

   assert_highz_float_R9: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_q == OP_HIGHZ) |-> (pin_oe == '0));

   assert_tdo_oe_R10: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (state == ST_SHF_IR || state == ST_SHF_DR));

   assert_not_ready_R11: assert property (@(posedge tck) disable iff (!trst_n)
      !ready |=> (state == ST_RESET));

endmodule

bind jtag_tap_ctrl tap_ctrl_chk #(.NPINS(NPINS)) u_chk (
   .tck    (tck),
   .trst_n (trst_n),
   .ready  (ready),
   .tms    (tms),
   .state  (state),
   .ir_q   (ir_q),
   .tdo_oe (tdo_oe),
   .pin_oe (pin_oe)
);

// File: tb/tb_jtag_tap_ctrl.sv
module tb_jtag_tap_ctrl;

   localparam int          NP   = 8;
   localparam logic [31:0] IDV  = 32'h1234_50DD;

   typedef struct packed {
      logic [9:0]  op;
      logic [5:0]  len;
      logic [31:0] exp;
   } vec_t;

   // R4/R5/R6/R7 table: opcode, scan length, expected capture (tdi held 0)
   localparam vec_t TBL [7] = '{
      '{op: 10'h006, len: 6'd32, exp: IDV},
      '{op: 10'h007, len: 6'd32, exp: 32'hFFFF_FFFF},
      '{op: 10'h3FF, len: 6'd1,  exp: 32'h0},
      '{op: 10'h00B, len: 6'd1,  exp: 32'h0},
      '{op: 10'h155, len: 6'd1,  exp: 32'h0},
      '{op: 10'h005, len: 6'd16, exp: 32'h0000_A53C},
      '{op: 10'h00F, len: 6'd16, exp: 32'h0000_A53C}
   };

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic ready = 1'b1;
   logic tdo, tdo_oe;
   logic [NP-1:0] core_out = 8'h3C;
   logic [NP-1:0] core_oe  = 8'h0F;
   logic [NP-1:0] pin_in   = 8'hA5;
   logic [NP-1:0] pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   logic last_tdo;
   logic oe_seen;

   always #10 tck = ~tck;

   jtag_tap_ctrl #(.NPINS(NP), .ID_VALUE(IDV)) dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ready(ready),
      .tdo(tdo), .tdo_oe(tdo_oe), .core_out(core_out), .core_oe(core_oe),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input logic ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      last_tdo = tdo;
      if (tdo_oe) oe_seen = 1'b1;
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #2;
   endtask

   task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 10; i++) begin
         step(i == 9, op[i]);
         cap[i] = last_tdo;
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(input int len, input logic [63:0] pat,
                          output logic [63:0] cap);
      cap = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < len; i++) begin
         step(i == len - 1, pat[i]);
         cap[i] = last_tdo;
      end
      step(1, 0); step(0, 0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [9:0]  ircap;
      logic [63:0] cap;
      logic        t0, tmid, t1;

      oe_seen = 1'b0;
      repeat (3) @(posedge tck);
      @(negedge tck); #2;
      trst_n = 1'b1;
      // R10 reset state of the serial port and pins
      check(tdo_oe == 1'b0, "R10 reset tdo_oe", 64'(tdo_oe), 64'h0);
      check(pin_out == core_out && pin_oe == core_oe, "R2 reset pins follow core",
            {pin_out, pin_oe}, {core_out, core_oe});
      step(0, 0);
      // R2 identification after reset
      scan_dr(32, 0, cap);
      check(cap[31:0] == IDV, "R2 id after reset", cap, 64'(IDV));
      check(tdo_oe == 1'b0, "R10 tdo_oe low in idle", 64'(tdo_oe), 64'h0);

      // Table walk: R3, R4, R5, R6, R7, R9
      for (int k = 0; k < 7; k++) begin
         load_ir(TBL[k].op, ircap);
         check(ircap == 10'h001, "R3 ir capture", 64'(ircap), 64'h001);
         if (TBL[k].op == 10'h00B)
            check(pin_oe == '0, "R9 float disables pins", 64'(pin_oe), 64'h0);
         scan_dr(TBL[k].len, 0, cap);
         check(cap[31:0] == TBL[k].exp, "R4 R5 R6 R7 table capture",
               cap, 64'(TBL[k].exp));
      end

      // R5 bypass delays tdi by one shift
      load_ir(10'h3FF, ircap);
      scan_dr(8, 64'hB3, cap);
      check(cap[7:0] == 8'h66, "R5 bypass delay", cap, 64'h66);

      // R7 preload then R8 external test
      load_ir(10'h005, ircap);
      scan_dr(16, 64'h0096, cap);
      check(cap[15:0] == 16'hA53C, "R7 sample capture", cap, 64'hA53C);
      check(pin_out == core_out && pin_oe == core_oe, "R7 sample leaves pins",
            {pin_out, pin_oe}, {core_out, core_oe});
      load_ir(10'h00F, ircap);
      check(pin_out == 8'h96, "R8 extest drives latch", 64'(pin_out), 64'h96);
      check(pin_oe == 8'hFF, "R8 extest enables", 64'(pin_oe), 64'hFF);

      // R10 tdo changes on the falling edge only
      load_ir(10'h006, ircap);
      step(1, 0); step(0, 0); step(0, 0);
      t0 = tdo;
      tms = 0;
      @(posedge tck); #1;
      tmid = tdo;
      @(negedge tck); #2;
      t1 = tdo;
      check(t0 == IDV[0] && tdo_oe, "R10 first bit on falling edge", 64'(t0), 64'(IDV[0]));
      check(tmid == IDV[0], "R10 holds across rising edge", 64'(tmid), 64'(IDV[0]));
      check(t1 == IDV[1], "R10 next bit after falling edge", 64'(t1), 64'(IDV[1]));

      // R1 five tms ones from Shift-DR after selecting bypass
      load_ir(10'h3FF, ircap);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0);
      scan_dr(32, 0, cap);
      check(cap[31:0] == IDV, "R1 five ones reset", cap, 64'(IDV));

      // R1 asynchronous trst
      load_ir(10'h007, ircap);
      #3 trst_n = 1'b0;
      #5 trst_n = 1'b1;
      @(negedge tck); #2;
      step(0, 0);
      scan_dr(32, 0, cap);
      check(cap[31:0] == IDV, "R1 trst reset", cap, 64'(IDV));

      // R11 not ready holds reset: scans are ignored
      ready = 1'b0;
      oe_seen = 1'b0;
      step(0, 0);
      load_ir(10'h007, ircap);
      scan_dr(32, 0, cap);
      check(oe_seen == 1'b0, "R11 no shift while not ready", 64'(oe_seen), 64'h0);
      ready = 1'b1;
      step(0, 0);
      scan_dr(32, 0, cap);
      check(cap[31:0] == IDV, "R11 ir untouched while not ready", cap, 64'(IDV));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule